// File: doc/BRIEF.md
# Flag-Setting Integer Arithmetic Unit

This block is the integer datapath stage of a processor pipeline. On each accepted cycle it takes two 32-bit operands and an operation code and produces one registered 32-bit result. Its six arithmetic forms are add, add with carry, subtract, subtract with carry, and two reversed subtracts. Its four bitwise forms are AND, XOR, OR and clear-bits. It also has signed saturating add and subtract. It keeps a registered condition-flag set: negative (N), zero (Z), carry (C), overflow (V) and a sticky saturation flag (Q). The carry-in for the with-carry forms is the current registered C flag.

A set-flags input selects whether an accepted operation may change N, Z, C and V. A separate flag-write port loads all five flags at once. This port is how the surrounding logic restores state or clears Q. The result and the updated flags become visible together, one clock after the accepting edge, and an output strobe marks that cycle. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `flag_alu`

## Requirements
- R1: Addition (op 0) gives a+b with C set when the 32-bit result is unsigned below a. Add-with-carry (op 1) gives a+b+C; with carry-in set, C becomes (result <= a), and with carry-in clear it uses the strict below rule.
- R2: Subtraction (op 2) gives a-b with C = (a >= b) unsigned, so C=1 means no borrow. Subtract-with-carry (op 3) gives a-b-1 and C = (a > b) when carry-in is clear, and gives a-b and C = (a >= b) when carry-in is set.
- R3: Reverse subtract (op 4) gives b-a with C = (b >= a). Reverse subtract-with-carry (op 5) gives b-a-1 with C = (b > a) when carry-in is clear, and b-a with C = (b >= a) when it is set.
- R4: V is bit 31 of (~(a^b)) & (a^result) for ops 0 and 1. It is bit 31 of (a^b) & (a^result) for ops 2 and 3, and of (b^a) & (b^result) for ops 4 and 5.
- R5: For ops 0 to 9 with set-flags high, N becomes result bit 31 and Z becomes 1 exactly when the result is zero.
- R6: AND (op 6), XOR (op 7), OR (op 8) and a AND NOT b (op 9) leave C and V unchanged even with set-flags high.
- R7: Saturating add (op 10) overflows when a and b have the same sign and a+b has the other sign. On overflow the result is 0x80000000 if a is negative and 0x7FFFFFFF otherwise, and Q is set.
- R8: Saturating subtract (op 11) overflows when a and b differ in sign and a-b differs in sign from a. It clamps the same way as R7 and sets Q.
- R9: Q is sticky: only reset or a flag write clears it. Saturating ops never change N, Z, C or V, and they set Q on overflow whatever the set-flags input is.
- R10: With set-flags low, an accepted op leaves N, Z, C and V at their previous values.
- R11: A flag write loads {N,Z,C,V,Q} from data bits 4 down to 0 one clock later. In the same cycle it takes priority over any flag update from an operation, but the result is still written.
- R12: Result and flags appear one clock after the accepting edge, and out_valid is high in exactly that cycle. Without in_valid the result holds.
- R13: After reset the result, all flags and out_valid are zero.
- R14: Op codes 12 to 15 give a zero result and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept operands and op this cycle |
| op | input | 4 | Operation code |
| opa | input | 32 | First operand (a) |
| opb | input | 32 | Second operand (b) |
| set_flags | input | 1 | Allow N, Z, C, V update |
| flag_wr | input | 1 | Load all flags from flag_wdata |
| flag_wdata | input | 5 | Flag load value {N,Z,C,V,Q} |
| result | output | 32 | Registered result |
| out_valid | output | 1 | Result and flags updated this cycle |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_q | output | 1 | Sticky saturation flag |

## Verification
The result, all five flags and out_valid are registered once, so each is due exactly one clock after the edge that samples in_valid or flag_wr. No result is due sooner or later than that edge. The bench changes inputs only on falling edges and lets one rising edge pass. It then reads the outputs on the next falling edge, and it drops in_valid at that point so that each operation is counted once. The same one-clock window is used for flag writes, for the cycles that check a held value, and for reading the carry that a with-carry operation then consumes.

// File: rtl/flag_alu_pkg.sv
`timescale 1ns/1ps
package flag_alu_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_RSB  = 4'd4,
    OP_RSC  = 4'd5,
    OP_AND  = 4'd6,
    OP_XOR  = 4'd7,
    OP_ORR  = 4'd8,
    OP_BIC  = 4'd9,
    OP_QADD = 4'd10,
    OP_QSUB = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
    logic q;
  } alu_flags_t;
endpackage

// File: rtl/flag_alu_arith.sv
`timescale 1ns/1ps
module flag_alu_arith
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  x_op;
  logic [W-1:0]  y_op;
  logic          c_in;
  logic [SW-1:0] sum;

  // One adder serves all six forms: subtraction adds the inverted operand.
  always_comb begin
    x_op = a;
    y_op = b;
    c_in = 1'b0;
    case (op)
      OP_ADD: begin x_op = a; y_op = b;  c_in = 1'b0; end
      OP_ADC: begin x_op = a; y_op = b;  c_in = cin;  end
      OP_SUB: begin x_op = a; y_op = ~b; c_in = 1'b1; end
      OP_SBC: begin x_op = a; y_op = ~b; c_in = cin;  end
      OP_RSB: begin x_op = b; y_op = ~a; c_in = 1'b1; end
      OP_RSC: begin x_op = b; y_op = ~a; c_in = cin;  end
      default: begin x_op = a; y_op = b; c_in = 1'b0; end
    endcase
  end

  assign sum   = {1'b0, x_op} + {1'b0, y_op} + SW'(c_in);
  assign res   = sum[W-1:0];
  assign c_out = sum[W];
  assign v_out = (x_op[W-1] == y_op[W-1]) && (res[W-1] != x_op[W-1]);
endmodule

// File: rtl/flag_alu_logic.sv
`timescale 1ns/1ps
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_ORR:  res = a | b;
      OP_BIC:  res = a & ~b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu_sat.sv
`timescale 1ns/1ps
module flag_alu_sat
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] raw;
  logic         same_sign;

  assign raw       = do_sub ? (a - b) : (a + b);
  assign same_sign = (a[W-1] == b[W-1]);
  assign ovf       = (raw[W-1] != a[W-1]) && (do_sub ? !same_sign : same_sign);
  assign res       = ovf ? (a[W-1] ? MOST_NEG : MOST_POS) : raw;
endmodule

// File: rtl/flag_alu.sv
`timescale 1ns/1ps
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         set_flags,
  input  logic         flag_wr,
  input  logic [4:0]   flag_wdata,
  output logic [W-1:0] result,
  output logic         out_valid,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic         flag_q
);
  localparam int unsigned SYNC_STAGES = 2;

  // Reset synchronizer: asserts asynchronously, releases on the clock.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // Operation units
  logic [W-1:0] arith_res, logic_res, sat_res;
  logic         arith_c, arith_v, sat_ovf;
  alu_flags_t   flags_q, flags_d;

  flag_alu_arith #(.W(W)) u_arith (
    .a(opa), .b(opb), .op(op), .cin(flags_q.c),
    .res(arith_res), .c_out(arith_c), .v_out(arith_v)
  );

  flag_alu_logic #(.W(W)) u_logic (
    .a(opa), .b(opb), .op(op), .res(logic_res)
  );

  flag_alu_sat #(.W(W)) u_sat (
    .a(opa), .b(opb), .do_sub(op == OP_QSUB), .res(sat_res), .ovf(sat_ovf)
  );

  // Next-state logic
  logic         is_arith, is_logic, is_sat;
  logic [W-1:0] res_d;
  logic         res_en, flag_en;

  assign is_arith = (op <= OP_RSC);
  assign is_logic = (op >= OP_AND) && (op <= OP_BIC);
  assign is_sat   = (op == OP_QADD) || (op == OP_QSUB);
  assign res_en   = in_valid;
  assign flag_en  = in_valid || flag_wr;

  always_comb begin
    if (is_arith)      res_d = arith_res;
    else if (is_logic) res_d = logic_res;
    else if (is_sat)   res_d = sat_res;
    else               res_d = '0;
  end

  always_comb begin
    flags_d = flags_q;
    if (in_valid) begin
      if (set_flags && (is_arith || is_logic)) begin
        flags_d.n = res_d[W-1];
        flags_d.z = (res_d == '0);
        if (is_arith) begin
          flags_d.c = arith_c;
          flags_d.v = arith_v;
        end
      end
      if (is_sat && sat_ovf) flags_d.q = 1'b1;
    end
    if (flag_wr) flags_d = alu_flags_t'(flag_wdata);
  end

  // Registers
  logic [W-1:0] res_q;
  logic         valid_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q   <= '0;
      flags_q <= '0;
      valid_q <= 1'b0;
    end else begin
      if (res_en)  res_q   <= res_d;
      if (flag_en) flags_q <= flags_d;
      valid_q <= in_valid;
    end
  end

  assign result    = res_q;
  assign out_valid = valid_q;
  assign flag_n    = flags_q.n;
  assign flag_z    = flags_q.z;
  assign flag_c    = flags_q.c;
  assign flag_v    = flags_q.v;
  assign flag_q    = flags_q.q;
endmodule

// File: rtl/flag_alu_chk.sv
`timescale 1ns/1ps
module flag_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  op,
  input logic        set_flags,
  input logic        flag_wr,
  input logic [4:0]  flag_wdata,
  input logic [31:0] result,
  input logic        out_valid,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_c,
  input logic        flag_v,
  input logic        flag_q
);
  logic upd_nz;
  assign upd_nz = in_valid && set_flags && !flag_wr && (op <= 4'd9);

  AST_OUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R12
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result))); // R12
  AST_NZ_FROM_RES: assert property (@(posedge clk) disable iff (!rst_n)
    upd_nz |=> ((flag_z == (result == 32'd0)) && (flag_n == result[31]))); // R5
  AST_LOGIC_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_nz && op >= 4'd6) |=> $stable({flag_c, flag_v})); // R6
  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_wr) |=> flag_q); // R9
  AST_SAT_KEEP_NZCV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flag_wr && (op == 4'd10 || op == 4'd11)) |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R9
  AST_NOSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !set_flags && !flag_wr) |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R10
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> ({flag_n, flag_z, flag_c, flag_v, flag_q} == $past(flag_wdata))); // R11
  AST_SPARE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flag_wr && op >= 4'd12) |=> ((result == 32'd0) && $stable({flag_n, flag_z, flag_c, flag_v, flag_q}))); // R14
endmodule

bind flag_alu flag_alu_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .op(op),
  .set_flags(set_flags), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
  .result(result), .out_valid(out_valid), .flag_n(flag_n), .flag_z(flag_z),
  .flag_c(flag_c), .flag_v(flag_v), .flag_q(flag_q)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, set_flags, flag_wr;
  logic [3:0]  op;
  logic [31:0] opa, opb, result;
  logic [4:0]  flag_wdata;
  logic        out_valid, flag_n, flag_z, flag_c, flag_v, flag_q;

  int n_checks = 0;
  int n_fails  = 0;
  logic m_n = 0, m_z = 0, m_c = 0, m_v = 0, m_q = 0;

  always #10 clk = ~clk; // 50 MHz

  flag_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
    .set_flags(set_flags), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .result(result), .out_valid(out_valid), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .flag_q(flag_q)
  );

  function automatic logic [4:0] dut_flags();
    return {flag_n, flag_z, flag_c, flag_v, flag_q};
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary_and_end();
  end

  // Reference values computed from the requirement text.
  task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic sf, output logic [31:0] r);
    logic c, v, arith, logic_op, ovf;
    c = m_c; v = m_v; arith = (o <= 4'd5); logic_op = (o >= 4'd6 && o <= 4'd9);
    r = 32'd0;
    case (o)
      4'd0: begin r = a + b; c = (r < a); v = ((~(a ^ b)) & (a ^ r)) >> 31; end
      4'd1: begin r = a + b + {31'd0, m_c}; c = m_c ? (r <= a) : (r < a); v = ((~(a ^ b)) & (a ^ r)) >> 31; end
      4'd2: begin r = a - b; c = (a >= b); v = ((a ^ b) & (a ^ r)) >> 31; end
      4'd3: begin r = a - b - {31'd0, ~m_c}; c = m_c ? (a >= b) : (a > b); v = ((a ^ b) & (a ^ r)) >> 31; end
      4'd4: begin r = b - a; c = (b >= a); v = ((b ^ a) & (b ^ r)) >> 31; end
      4'd5: begin r = b - a - {31'd0, ~m_c}; c = m_c ? (b >= a) : (b > a); v = ((b ^ a) & (b ^ r)) >> 31; end
      4'd6: r = a & b;
      4'd7: r = a ^ b;
      4'd8: r = a | b;
      4'd9: r = a & ~b;
      4'd10: begin
        r = a + b; ovf = (a[31] == b[31]) && (r[31] != a[31]);
        if (ovf) begin r = a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF; m_q = 1'b1; end
      end
      4'd11: begin
        r = a - b; ovf = (a[31] != b[31]) && (r[31] != a[31]);
        if (ovf) begin r = a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF; m_q = 1'b1; end
      end
      default: r = 32'd0;
    endcase
    if (sf && (arith || logic_op)) begin
      m_n = r[31]; m_z = (r == 32'd0);
      if (arith) begin m_c = c; m_v = v; end
    end
  endtask

  task automatic do_op(input string req, input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic sf);
    logic [31:0] exp_r;
    model(o, a, b, sf, exp_r);
    op = o; opa = a; opb = b; set_flags = sf; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check(req, "result", 64'(result), 64'(exp_r));
    check(req, "flags NZCVQ", 64'(dut_flags()), 64'({m_n, m_z, m_c, m_v, m_q}));
  endtask

  task automatic load_flags(input logic [4:0] f);
    flag_wr = 1'b1; flag_wdata = f;
    @(posedge clk); @(negedge clk);
    flag_wr = 1'b0;
    {m_n, m_z, m_c, m_v, m_q} = f;
    check("R11", "flag load", 64'(dut_flags()), 64'(f));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 0; set_flags = 0; flag_wr = 0; flag_wdata = 0;
    op = 0; opa = 0; opb = 0;
    repeat (3) @(negedge clk);
    check("R13", "result", 64'(result), 64'd0);
    check("R13", "flags", 64'(dut_flags()), 64'd0);
    check("R13", "out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_add();
    do_op("R1", 4'd0, 32'd5, 32'd7, 1'b1);
    do_op("R1", 4'd0, 32'hFFFF_FFFF, 32'd1, 1'b1);       // wrap to zero, C=1, Z=1
    do_op("R4", 4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1);       // signed overflow
    load_flags(5'b00100);
    do_op("R1", 4'd1, 32'd10, 32'hFFFF_FFFF, 1'b1);      // carry-in set, result == a
    load_flags(5'b00000);
    do_op("R1", 4'd1, 32'd10, 32'hFFFF_FFFF, 1'b1);      // carry-in clear
  endtask

  task automatic t_sub();
    do_op("R2", 4'd2, 32'd9, 32'd9, 1'b1);               // equal: C=1, Z=1
    do_op("R2", 4'd2, 32'd3, 32'd9, 1'b1);               // borrow: C=0
    do_op("R4", 4'd2, 32'h8000_0000, 32'd1, 1'b1);       // signed overflow
    load_flags(5'b00000);
    do_op("R2", 4'd3, 32'd5, 32'd5, 1'b1);               // carry clear, a==b: C=0
    load_flags(5'b00100);
    do_op("R2", 4'd3, 32'd5, 32'd5, 1'b1);               // carry set, a==b: C=1
  endtask

  task automatic t_rsub();
    do_op("R3", 4'd4, 32'd4, 32'd20, 1'b1);
    do_op("R3", 4'd4, 32'd20, 32'd4, 1'b1);
    load_flags(5'b00000);
    do_op("R3", 4'd5, 32'd7, 32'd7, 1'b1);
    load_flags(5'b00100);
    do_op("R3", 4'd5, 32'd7, 32'd7, 1'b1);
    do_op("R4", 4'd4, 32'd1, 32'h8000_0000, 1'b1);
  endtask

  task automatic t_logic();
    load_flags(5'b00110);
    do_op("R6", 4'd6, 32'hF0F0_1234, 32'h0F0F_FFFF, 1'b1);
    do_op("R6", 4'd7, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1);
    do_op("R5", 4'd8, 32'h8000_0000, 32'h0000_0001, 1'b1);
    do_op("R6", 4'd9, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b1);
  endtask

  task automatic t_sat();
    load_flags(5'b00000);
    do_op("R7", 4'd10, 32'd100, 32'd200, 1'b1);          // no overflow, Q stays 0
    do_op("R7", 4'd10, 32'h7FFF_FFF0, 32'h100, 1'b1);    // clamp positive
    load_flags(5'b00000);
    do_op("R7", 4'd10, 32'h8000_0001, 32'hFFFF_FF00, 1'b0); // clamp negative, set_flags low
    load_flags(5'b10010);
    do_op("R8", 4'd11, 32'h8000_0000, 32'd1, 1'b1);      // clamp negative
    do_op("R8", 4'd11, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1); // clamp positive
    do_op("R8", 4'd11, 32'd50, 32'd8, 1'b1);
  endtask

  task automatic t_sticky();
    do_op("R9", 4'd10, 32'd1, 32'd1, 1'b1);              // Q already set, stays
    do_op("R9", 4'd0, 32'd0, 32'd0, 1'b1);
    check("R9", "Q after plain op", 64'(flag_q), 64'd1);
    load_flags(5'b00000);
    check("R9", "Q cleared by write", 64'(flag_q), 64'd0);
  endtask

  task automatic t_noset();
    load_flags(5'b01010);
    do_op("R10", 4'd2, 32'd1, 32'd2, 1'b0);
    do_op("R10", 4'd7, 32'hFFFF_FFFF, 32'd0, 1'b0);
  endtask

  task automatic t_priority();
    logic [31:0] dummy;
    model(4'd0, 32'd3, 32'd4, 1'b1, dummy);
    op = 4'd0; opa = 32'd3; opb = 32'd4; set_flags = 1'b1; in_valid = 1'b1;
    flag_wr = 1'b1; flag_wdata = 5'b10101;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; flag_wr = 1'b0;
    {m_n, m_z, m_c, m_v, m_q} = 5'b10101;
    check("R11", "result with flag write", 64'(result), 64'd7);
    check("R11", "flag write wins", 64'(dut_flags()), 64'h15);
  endtask

  task automatic t_spare();
    do_op("R14", 4'd13, 32'h1234_5678, 32'h9, 1'b1);
    do_op("R14", 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
  endtask

  task automatic t_timing();
    logic [31:0] held;
    do_op("R12", 4'd0, 32'd40, 32'd2, 1'b1);
    check("R12", "out_valid after accept", 64'(out_valid), 64'd1);
    held = result;
    op = 4'd2; opa = 32'd999; opb = 32'd1; set_flags = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R12", "result held while idle", 64'(result), 64'(held));
    check("R12", "out_valid idle", 64'(out_valid), 64'd0);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_rsub();
    t_logic();
    t_sat();
    t_sticky();
    t_noset();
    t_priority();
    t_spare();
    t_timing();
    summary_and_end();
  end
endmodule